// File: doc/BRIEF.md
# Alternating Spacer Dual-Rail Register

This block is a clocked register for a word of dual-rail bits. Each logical bit travels on two rails. The register stores the code word it sees at the rising clock edge. While the clock is low it drives the stored word out in dual-rail form. While the clock is high it drives a spacer onto every rail pair instead of data.

The spacer changes polarity from one clock cycle to the next: all-zeroes in one cycle, all-ones in the following one. As a result, each rail of every pair makes the same number of transitions in every cycle, whatever the data. The polarity comes from a half-rate phase signal that toggles on each falling clock edge. The register reports this signal on `spacer_phase`, so that the logic feeding the register can inject the same spacer in the same cycle. Reset sets that phase to a known value.

Inside, the block has:
- a master stage that captures the word on the rising edge;
- a slave stage that updates on the falling edge;
- the phase toggle;
- a spacer injector that selects, by clock level, between the slave contents and the current spacer.

An input pair that is a spacer at capture time is not stored, and it raises an error flag.

Top module: `asdr_reg`

## Requirements
- R1: Pair i sits on rails [2i+1] (true rail) and [2i] (false rail), on both the input and the output. {10} encodes logic 1 and {01} encodes logic 0. {00} is the low spacer and {11} is the high spacer.
- R2: While `rst_n` is low, every output pair is {00}, `spacer_phase` is 0 and `err_o` is 0.
- R3: A word whose pairs are all valid at a rising edge of `clk` appears as code words on `dout_rails` throughout the low phase that follows the next falling edge.
- R4: While `clk` is high, every output pair carries the same spacer. That spacer is {11} when `spacer_phase` is 1 and {00} when it is 0.
- R5: `spacer_phase` inverts at every falling edge of `clk` after reset release and holds at all other times. The first spacer after reset is {00}.
- R6: From the first falling edge after reset release, each output pair changes exactly one rail in every half clock period, for any data sequence.
- R7: An input pair of {00} or {11} at a rising edge leaves that bit's stored value unchanged. Valid pairs in the same word are still captured.
- R8: With STICKY_ERR=1, `err_o` goes to 1 after a rising edge that sees any invalid input pair, and it stays at 1 until reset. With STICKY_ERR=0, `err_o` reports only the most recent capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The high phase carries spacers and the low phase carries data. |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_rails | input | 2*WIDTH | Dual-rail input word, captured on the rising edge |
| dout_rails | output | 2*WIDTH | Dual-rail output word, following the alternating spacer protocol |
| spacer_phase | output | 1 | Half-rate phase that selects the spacer polarity |
| err_o | output | 1 | Set when an invalid input pair has been seen at capture |

## Verification
The assertions check four things in every cycle:
- every pair carries the spacer that `spacer_phase` selects during the high phase;
- every pair carries a valid code word during the low phase;
- the phase inverts between consecutive falling edges;
- an invalid pair at capture raises the error flag, which then stays set.

Only the bench scenarios can show the rest. These are which value each bit holds after mixed valid and invalid words, and that exactly one rail moves per pair in every half period across a full sweep of input patterns. They also cover the reset values and the restart of the phase after a second reset.

// File: rtl/asdr_pkg.sv
package asdr_pkg;

   typedef logic [1:0] rail_pair_t;

   localparam rail_pair_t PAIR_SPACER_LO = 2'b00;
   localparam rail_pair_t PAIR_SPACER_HI = 2'b11;
   localparam rail_pair_t PAIR_CODE_ONE  = 2'b10;
   localparam rail_pair_t PAIR_CODE_ZERO = 2'b01;

   // A pair is a code word when exactly one rail is high
   function automatic logic pair_is_code(input rail_pair_t p);
      return p[1] ^ p[0];
   endfunction

   function automatic rail_pair_t encode_bit(input logic b);
      return b ? PAIR_CODE_ONE : PAIR_CODE_ZERO;
   endfunction

   function automatic rail_pair_t spacer_of(input logic polarity);
      return polarity ? PAIR_SPACER_HI : PAIR_SPACER_LO;
   endfunction

endpackage

// File: rtl/asdr_capture.sv
// Master stage: captures valid pairs on the rising edge, flags invalid ones
module asdr_capture
   import asdr_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int STICKY_ERR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*WIDTH-1:0] din_rails,
   output logic [WIDTH-1:0]   master_q,
   output logic               err_q
);

   logic [WIDTH-1:0] pair_ok;
   logic             any_bad;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rail_pair_t pair;
      logic       bit_q;

      assign pair       = din_rails[2*i +: 2];
      assign pair_ok[i] = pair_is_code(pair);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (pair_ok[i])
            bit_q <= pair[1];
      end

      assign master_q[i] = bit_q;
   end

   assign any_bad = ~&pair_ok;

   if (STICKY_ERR != 0) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            err_q <= 1'b0;
         else
            err_q <= err_q | any_bad;
      end
   end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            err_q <= 1'b0;
         else
            err_q <= any_bad;
      end
   end

endmodule

// File: rtl/asdr_slave.sv
// Slave stage: copies the master on the falling edge and records the first update
module asdr_slave #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] master_q,
   output logic [WIDTH-1:0] slave_q,
   output logic             primed
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_q <= '0;
         primed  <= 1'b0;
      end else begin
         slave_q <= master_q;
         primed  <= 1'b1;
      end
   end

endmodule

// File: rtl/asdr_phase_toggle.sv
// Half-rate toggle that selects the spacer polarity, inverting on the falling edge
module asdr_phase_toggle (
   input  logic clk,
   input  logic rst_n,
   output logic phase_q
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= 1'b0;
      else
         phase_q <= ~phase_q;
   end

endmodule

// File: rtl/asdr_inject.sv
// Output stage: spacer while the clock is high, stored code word while it is low
module asdr_inject
   import asdr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               primed,
   input  logic               phase,
   input  logic [WIDTH-1:0]   slave_q,
   output logic [2*WIDTH-1:0] dout_rails
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pair
      rail_pair_t pair_out;

      always_comb begin
         if (!rst_n)
            pair_out = PAIR_SPACER_LO;
         else if (clk || !primed)
            pair_out = spacer_of(phase);
         else
            pair_out = encode_bit(slave_q[i]);
      end

      assign dout_rails[2*i +: 2] = pair_out;
   end

endmodule

// File: rtl/asdr_reg.sv
// Alternating spacer dual-rail register (top)
module asdr_reg #(
   parameter int WIDTH      = 8,
   parameter int STICKY_ERR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*WIDTH-1:0] din_rails,
   output logic [2*WIDTH-1:0] dout_rails,
   output logic               spacer_phase,
   output logic               err_o
);

   localparam int RAIL_W = 2 * WIDTH;

   if (WIDTH < 1) begin : g_bad_width
      $error("asdr_reg: WIDTH must be at least 1");
   end
   if (STICKY_ERR != 0 && STICKY_ERR != 1) begin : g_bad_sticky
      $error("asdr_reg: STICKY_ERR must be 0 or 1");
   end

   logic [WIDTH-1:0]  master_q;
   logic [WIDTH-1:0]  slave_q;
   logic              primed;
   logic              phase_q;
   logic [RAIL_W-1:0] rails_out;

   asdr_capture #(.WIDTH(WIDTH), .STICKY_ERR(STICKY_ERR)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .din_rails (din_rails),
      .master_q  (master_q),
      .err_q     (err_o)
   );

   asdr_slave #(.WIDTH(WIDTH)) u_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .master_q (master_q),
      .slave_q  (slave_q),
      .primed   (primed)
   );

   asdr_phase_toggle u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_q (phase_q)
   );

   asdr_inject #(.WIDTH(WIDTH)) u_inject (
      .clk        (clk),
      .rst_n      (rst_n),
      .primed     (primed),
      .phase      (phase_q),
      .slave_q    (slave_q),
      .dout_rails (rails_out)
   );

   assign dout_rails   = rails_out;
   assign spacer_phase = phase_q;

endmodule

// File: rtl/asdr_reg_chk.sv
// Protocol checker bound to the register
module asdr_reg_chk #(
   parameter int WIDTH      = 8,
   parameter int STICKY_ERR = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*WIDTH-1:0] din_rails,
   input logic [2*WIDTH-1:0] dout_rails,
   input logic               spacer_phase,
   input logic               err_o
);

   logic seen_fall;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_fall <= 1'b0;
      else
         seen_fall <= 1'b1;
   end

   function automatic logic all_code(input logic [2*WIDTH-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < WIDTH; i++)
         if (v[2*i] == v[2*i+1]) ok = 1'b0;
      return ok;
   endfunction

   // Values sampled at a falling edge belong to the high phase
   AST_SPACER_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
      dout_rails == {2*WIDTH{spacer_phase}}); // R4

   // Values sampled at a rising edge belong to the low phase
   AST_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      seen_fall |-> all_code(dout_rails)); // R3

   AST_PHASE_FLIP: assert property (@(negedge clk) disable iff (!rst_n)
      seen_fall |-> (spacer_phase != $past(spacer_phase))); // R5

   AST_INVALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !all_code(din_rails) |=> err_o); // R8

   if (STICKY_ERR != 0) begin : g_sticky_chk
      AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         $past(err_o) |-> err_o); // R8
   end

endmodule

bind asdr_reg asdr_reg_chk #(.WIDTH(WIDTH), .STICKY_ERR(STICKY_ERR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .din_rails    (din_rails),
   .dout_rails   (dout_rails),
   .spacer_phase (spacer_phase),
   .err_o        (err_o)
);

// File: tb/tb_asdr_reg.sv
module tb_asdr_reg;

   localparam int W          = 3;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;

   logic           clk   = 1'b0;
   logic           rst_n = 1'b0;
   logic [2*W-1:0] din   = '0;
   logic [2*W-1:0] dout;
   logic           spacer_phase;
   logic           err;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   logic [W-1:0]   exp_word;
   logic           exp_err;
   logic           exp_phase;
   logic [2*W-1:0] prev_out;
   bit             trans_ok;

   asdr_reg #(.WIDTH(W), .STICKY_ERR(1)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .din_rails    (din),
      .dout_rails   (dout),
      .spacer_phase (spacer_phase),
      .err_o        (err)
   );

   always #(HALF) clk = ~clk;

   function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
      logic [2*W-1:0] r;
      for (int i = 0; i < W; i++) r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
      return r;
   endfunction

   task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, expv, $time);
      end
   endtask

   // R6: each pair moves exactly one rail per half period
   task automatic check_trans();
      if (trans_ok) begin
         for (int i = 0; i < W; i++)
            check("R6", 2'($countones(dout[2*i +: 2] ^ prev_out[2*i +: 2])), 2'd1);
      end
      prev_out = dout;
   endtask

   task automatic run_cycle(input logic [2*W-1:0] rails, input string tag);
      logic bad;
      bad = 1'b0;
      din = rails;
      for (int i = 0; i < W; i++) begin
         if (rails[2*i] ^ rails[2*i+1]) exp_word[i] = rails[2*i+1];
         else bad = 1'b1;
      end
      exp_err = exp_err | bad;
      @(posedge clk); #3;
      check("R4", dout, {2*W{exp_phase}});
      check("R5", {{(2*W-1){1'b0}}, spacer_phase}, {{(2*W-1){1'b0}}, exp_phase});
      check("R8", {{(2*W-1){1'b0}}, err}, {{(2*W-1){1'b0}}, exp_err});
      check_trans();
      @(negedge clk); #3;
      exp_phase = ~exp_phase;
      check(tag, dout, enc(exp_word));
      check("R5", {{(2*W-1){1'b0}}, spacer_phase}, {{(2*W-1){1'b0}}, exp_phase});
      check_trans();
      trans_ok = 1;
   endtask

   task automatic do_reset();
      @(negedge clk); #2;
      rst_n = 1'b0;
      din   = '0;
      #1;
      check("R2", dout, '0);
      check("R2", {{(2*W-1){1'b0}}, spacer_phase}, '0);
      check("R2", {{(2*W-1){1'b0}}, err}, '0);
      @(negedge clk); #2;
      rst_n     = 1'b1;
      exp_word  = '0;
      exp_err   = 1'b0;
      exp_phase = 1'b0;
      trans_ok  = 0;
      prev_out  = dout;
   endtask

   initial begin
      do_reset();
      // R1: every valid word, encoding checked at the output
      for (int w = 0; w < (1 << W); w++) run_cycle(enc(W'(w)), "R1");
      // R6: extreme data alternation, same transition count
      for (int k = 0; k < 4; k++) run_cycle(enc((k % 2) ? '1 : '0), "R6");
      // R7 / R3: every rail pattern including spacers on inputs
      for (int p = 0; p < (1 << (2*W)); p++) begin
         logic all_ok;
         all_ok = 1'b1;
         for (int i = 0; i < W; i++)
            if (p[2*i] == p[2*i+1]) all_ok = 1'b0;
         run_cycle((2*W)'(p), all_ok ? "R3" : "R7");
      end
      // R2 / R5: second reset restarts phase and clears the flag
      do_reset();
      run_cycle(enc(3'b101), "R3");
      run_cycle(enc(3'b010), "R3");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule